// File: doc/BRIEF.md
# Transport Stream PID Filter

This block sits on a byte-wide MPEG transport stream and forwards or discards whole 188-byte packets by their 13-bit packet identifier. Bytes arrive with a valid strobe and a start strobe on the first byte of each packet. The block reads the identifier from header bytes 1 and 2 and compares it with a bank of programmable match slots. Two global controls can override the slots. Accepted packets leave on a byte stream that uses the same valid and start strobes. Rejected packets leave no trace on the output.

The host programs the slots through a single-cycle write port and reads them back through a combinational read port. The slot at index 0 carries extra bits. These are the global controls (discard everything, forward everything) and the byte-order select, which is passed on to a downstream word packer. The header bytes that arrive before the decision are held in the block. When a packet is accepted, they are released at once into a small output queue, so the packet leaves complete and in order.

Top module: `ts_pid_filter`

## Requirements
- R1: After reset, slot 0 reads 0x03FFF (identifier field all ones, discard-all bit 13 set, everything else clear), slots 1 to 7 read 0x01FFF, out_valid is low and out_order is low.
- R2: A write stores into slot cfg_addr. Identifier bits 12:0 and enable bit 15 are kept in every slot. Slot 0 also keeps bit 13 (discard-all), bit 14 (byte order) and bit 16 (forward-all). All other bits read back as zero. cfg_rdata shows slot cfg_addr in the same cycle.
- R3: The identifier is {byte1[4:0], byte2}. A slot hits only when its enable bit is set and its identifier field equals the packet identifier. A packet is accepted when any slot hits.
- R4: When discard-all is set, no packet is forwarded. This holds even if forward-all is also set or a slot hits.
- R5: When forward-all is set and discard-all is clear, every packet with a good sync byte is forwarded, whatever its identifier.
- R6: An accepted packet leaves as all 188 bytes, unchanged and in order, with out_start on the first byte (0x47) only. A rejected packet produces no output bytes.
- R7: A packet whose start byte is not 0x47 is dropped. Valid bytes that arrive with no packet in progress are ignored until the next start strobe.
- R8: A start strobe in the middle of a packet ends that packet and begins a new one. Bytes already forwarded stay forwarded.
- R9: The first output byte (out_start high) appears in the cycle after the clock edge that samples an accepted header byte 2. The held bytes then follow one per cycle.
- R10: out_order always follows bit 14 of slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_start | input | 1 | Marks the first byte of a packet |
| in_data | input | 8 | Input byte |
| cfg_we | input | 1 | Slot write strobe |
| cfg_addr | input | 3 | Slot index for write and read |
| cfg_wdata | input | 17 | Slot write data |
| cfg_rdata | output | 17 | Slot read data (combinational) |
| out_valid | output | 1 | Output byte valid |
| out_start | output | 1 | First byte of a forwarded packet |
| out_data | output | 8 | Output byte |
| out_order | output | 1 | Byte-order select for the downstream packer |

## Verification
A slot write takes effect at the next clock edge. Register reads are combinational, so the bench checks them in the same low clock phase in which it drives the address. A packet's fate is known one edge after header byte 2, and its first byte is due in the next cycle. The bench checks that cycle directly with a single hand-driven header. For whole packets, a collector samples on the falling edge and compares every output byte with its expected value by position. Packet-level counts are checked only after a drain interval that is longer than the three-byte queue backlog.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  localparam int SLOT_W    = 17;
  localparam int PID_W     = 13;
  localparam int BIT_DROP  = 13;
  localparam int BIT_ORDER = 14;
  localparam int BIT_EN    = 15;
  localparam int BIT_PASS  = 16;
  localparam logic [7:0] SYNC_BYTE = 8'h47;
  localparam logic [SLOT_W-1:0] PARK_WORD  = 17'h01FFF;
  localparam logic [SLOT_W-1:0] BOOT_WORD0 = 17'h03FFF;
  localparam logic [SLOT_W-1:0] MASK_SLOT0 = 17'h1FFFF;
  localparam logic [SLOT_W-1:0] MASK_SLOTN = 17'h09FFF;

  typedef enum logic [2:0] {ST_IDLE, ST_HDR1, ST_HDR2, ST_FWD, ST_SKIP} fsm_t;

  function automatic logic [PID_W-1:0] pid_of(input logic [7:0] b1, input logic [7:0] b2);
    return {b1[4:0], b2};
  endfunction

  function automatic logic slot_hit(input logic [SLOT_W-1:0] w, input logic [PID_W-1:0] pid);
    return w[BIT_EN] && (w[PID_W-1:0] == pid);
  endfunction

  function automatic logic verdict(input logic drop, input logic pass, input logic any_hit);
    return !drop && (pass || any_hit);
  endfunction
endpackage

// File: rtl/tsf_slot_bank.sv
module tsf_slot_bank
  import tsf_pkg::*;
#(
  parameter int NSLOT = 8,
  localparam int AW = $clog2(NSLOT)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [AW-1:0]                 addr,
  input  logic [SLOT_W-1:0]             wdata,
  output logic [SLOT_W-1:0]             rdata,
  output logic [NSLOT-1:0][SLOT_W-1:0]  slots
);
  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    localparam logic [SLOT_W-1:0] KEEP = (i == 0) ? MASK_SLOT0 : MASK_SLOTN;
    localparam logic [SLOT_W-1:0] BOOT = (i == 0) ? BOOT_WORD0 : PARK_WORD;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slots[i] <= BOOT;
      else if (we && (addr == AW'(i)))
        slots[i] <= wdata & KEEP;
    end
  end

  assign rdata = slots[addr];
endmodule

// File: rtl/tsf_pid_match.sv
module tsf_pid_match
  import tsf_pkg::*;
#(
  parameter int NSLOT = 8
) (
  input  logic [NSLOT-1:0][SLOT_W-1:0] slots,
  input  logic [PID_W-1:0]             pid,
  output logic                         accept
);
  logic [NSLOT-1:0] hits;

  for (genvar i = 0; i < NSLOT; i++) begin : g_cmp
    assign hits[i] = slot_hit(slots[i], pid);
  end

  assign accept = verdict(slots[0][BIT_DROP], slots[0][BIT_PASS], |hits);
endmodule

// File: rtl/tsf_out_queue.sv
module tsf_out_queue #(
  parameter int QDEPTH = 4,
  localparam int QAW = $clog2(QDEPTH),
  localparam int CW  = $clog2(QDEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      push_n,
  input  logic            push_sop,
  input  logic [2:0][7:0] push_bytes,
  output logic            out_valid,
  output logic            out_start,
  output logic [7:0]      out_data,
  output logic [CW-1:0]   count
);
  logic [QDEPTH-1:0][8:0] mem;
  logic [QAW-1:0]         wp, rp;
  logic                   pop;

  assign pop       = (count != '0);
  assign out_valid = pop;
  assign out_start = pop && mem[rp][8];
  assign out_data  = mem[rp][7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem   <= '0;
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      for (int k = 0; k < 3; k++) begin
        if (k < int'(push_n))
          mem[wp + QAW'(k)] <= {(k == 0) && push_sop, push_bytes[k]};
      end
      wp    <= wp + QAW'(push_n);
      rp    <= rp + QAW'(pop);
      count <= count + CW'(push_n) - CW'(pop);
    end
  end
endmodule

// File: rtl/ts_pid_filter.sv
module ts_pid_filter
  import tsf_pkg::*;
#(
  parameter int NSLOT   = 8,
  parameter int PKT_LEN = 188,
  parameter int QDEPTH  = 4,
  localparam int AW    = $clog2(NSLOT),
  localparam int CNT_W = $clog2(PKT_LEN),
  localparam int CW    = $clog2(QDEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_start,
  input  logic [7:0]        in_data,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [SLOT_W-1:0] cfg_wdata,
  output logic [SLOT_W-1:0] cfg_rdata,
  output logic              out_valid,
  output logic              out_start,
  output logic [7:0]        out_data,
  output logic              out_order
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(PKT_LEN - 1);

  logic [NSLOT-1:0][SLOT_W-1:0] slots;
  fsm_t             state_q;
  logic [CNT_W-1:0] idx_q;
  logic [7:0]       hdr1_q;
  logic [PID_W-1:0] cur_pid;
  logic             accept;
  logic             decide_evt, accept_evt, drop_all, pass_all;
  logic [1:0]       push_n;
  logic             push_sop;
  logic [2:0][7:0]  push_bytes;
  logic [CW-1:0]    q_count;

  tsf_slot_bank #(.NSLOT(NSLOT)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .slots(slots)
  );

  assign cur_pid = pid_of(hdr1_q, in_data);

  tsf_pid_match #(.NSLOT(NSLOT)) u_match (
    .slots(slots), .pid(cur_pid), .accept(accept)
  );

  assign drop_all   = slots[0][BIT_DROP];
  assign pass_all   = slots[0][BIT_PASS];
  assign out_order  = slots[0][BIT_ORDER];
  assign decide_evt = in_valid && !in_start && (state_q == ST_HDR2);
  assign accept_evt = decide_evt && accept;

  always_comb begin
    push_n     = 2'd0;
    push_sop   = 1'b0;
    push_bytes = {in_data, hdr1_q, SYNC_BYTE};
    if (accept_evt) begin
      push_n   = 2'd3;
      push_sop = 1'b1;
    end else if (in_valid && !in_start && state_q == ST_FWD) begin
      push_n     = 2'd1;
      push_bytes = {8'h00, 8'h00, in_data};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      hdr1_q  <= '0;
    end else if (in_valid) begin
      if (in_start) begin
        state_q <= (in_data == SYNC_BYTE) ? ST_HDR1 : ST_IDLE;
        idx_q   <= CNT_W'(1);
      end else begin
        unique case (state_q)
          ST_IDLE: ;
          ST_HDR1: begin
            hdr1_q  <= in_data;
            state_q <= ST_HDR2;
            idx_q   <= CNT_W'(2);
          end
          ST_HDR2: begin
            state_q <= accept ? ST_FWD : ST_SKIP;
            idx_q   <= CNT_W'(3);
          end
          ST_FWD, ST_SKIP: begin
            if (idx_q == LAST_IDX) state_q <= ST_IDLE;
            idx_q <= idx_q + 1'b1;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  tsf_out_queue #(.QDEPTH(QDEPTH)) u_q (
    .clk(clk), .rst_n(rst_n), .push_n(push_n), .push_sop(push_sop),
    .push_bytes(push_bytes), .out_valid(out_valid), .out_start(out_start),
    .out_data(out_data), .count(q_count)
  );
endmodule

// File: rtl/tsf_checker.sv
module tsf_checker #(
  parameter int QDEPTH = 4,
  localparam int CW = $clog2(QDEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out_valid,
  input logic          out_start,
  input logic [7:0]    out_data,
  input logic          decide_evt,
  input logic          accept_evt,
  input logic          drop_all,
  input logic          pass_all,
  input logic [CW-1:0] q_count
);
  AST_SOP_IS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_start |-> out_data == 8'h47); // R6
  AST_DROP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    decide_evt && drop_all |-> !accept_evt); // R4
  AST_PASS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    decide_evt && pass_all && !drop_all |-> accept_evt); // R5
  AST_FIRST_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> out_valid && out_start); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    int'(q_count) <= QDEPTH); // R6
endmodule

bind ts_pid_filter tsf_checker #(.QDEPTH(QDEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_start(out_start),
  .out_data(out_data), .decide_evt(decide_evt), .accept_evt(accept_evt),
  .drop_all(drop_all), .pass_all(pass_all), .q_count(q_count)
);

// File: tb/tb_ts_pid_filter.sv
module tb_ts_pid_filter;
  localparam int CLK_NS = 10;
  localparam int PLEN   = 188;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_start = 0, cfg_we = 0;
  logic [7:0] in_data = 0;
  logic [2:0] cfg_addr = 0;
  logic [16:0] cfg_wdata = 0;
  logic [16:0] cfg_rdata;
  logic out_valid, out_start, out_order;
  logic [7:0] out_data;

  ts_pid_filter dut (.*);

  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int got_bytes = 0, got_starts = 0, mism = 0, oidx = 0;
  logic [12:0] exp_pid = 0;
  bit done = 0;

  function automatic logic [7:0] gen(input logic [12:0] pid, input int k);
    if (k == 0) return 8'h47;
    if (k == 1) return {3'b000, pid[12:8]};
    if (k == 2) return pid[7:0];
    return 8'((k * 3 + int'(pid)) & 255);
  endfunction

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && out_valid) begin
    if (out_start) begin got_starts++; oidx = 0; end
    if (out_data != gen(exp_pid, oidx)) mism++;
    got_bytes++;
    oidx++;
  end

  task automatic clear_col();
    got_bytes = 0; got_starts = 0; mism = 0; oidx = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [16:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic send(input logic [12:0] pid, input int n, input bit gap, input logic [7:0] b0);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1; in_start = (k == 0);
      in_data = (k == 0) ? b0 : gen(pid, k);
      if (gap) begin @(negedge clk); in_valid = 0; in_start = 0; end
    end
    @(negedge clk); in_valid = 0; in_start = 0;
  endtask

  task automatic drain();
    repeat (12) @(negedge clk);
  endtask

  typedef struct packed {
    logic [16:0] s0; logic [2:0] sidx; logic [16:0] sval;
    logic [12:0] pid; logic gap; logic exp;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{17'h03FFF, 3'd0, 17'h00000, 13'h0100, 1'b0, 1'b0}, // R4 discard-all idle
    '{17'h00000, 3'd3, 17'h08100, 13'h0100, 1'b0, 1'b1}, // R3 slot hit
    '{17'h00000, 3'd3, 17'h08100, 13'h0101, 1'b0, 1'b0}, // R3 miss by one
    '{17'h10000, 3'd0, 17'h00000, 13'h0055, 1'b0, 1'b1}, // R5 forward-all
    '{17'h12000, 3'd2, 17'h08055, 13'h0055, 1'b0, 1'b0}, // R4 beats pass and hit
    '{17'h08ABC, 3'd0, 17'h00000, 13'h0ABC, 1'b1, 1'b1}, // R3 slot 0 hit, gaps
    '{17'h00000, 3'd7, 17'h09FFF, 13'h1FFF, 1'b0, 1'b1}, // R3 all-ones id
    '{17'h00000, 3'd5, 17'h00022, 13'h0022, 1'b0, 1'b0}, // R3 disabled slot
    '{17'h14000, 3'd0, 17'h00000, 13'h0777, 1'b0, 1'b1}  // R5 with order bit
  };

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    @(negedge clk);
    cfg_addr = 0; #1 chk("R1 slot0", cfg_rdata == 17'h03FFF, cfg_rdata, 17'h03FFF);
    for (int s = 1; s < 8; s++) begin
      cfg_addr = 3'(s); #1 chk("R1 slotN", cfg_rdata == 17'h01FFF, cfg_rdata, 17'h01FFF);
    end
    chk("R1 out_valid", out_valid == 0, out_valid, 0);
    chk("R1 out_order", out_order == 0, out_order, 0);

    // R2 masking and read-back
    wr(3'd2, 17'h1FFFF);
    cfg_addr = 2; #1 chk("R2 slotN mask", cfg_rdata == 17'h09FFF, cfg_rdata, 17'h09FFF);
    wr(3'd0, 17'h1FFFF);
    cfg_addr = 0; #1 chk("R2 slot0 mask", cfg_rdata == 17'h1FFFF, cfg_rdata, 17'h1FFFF);
    chk("R10 order set", out_order == 1, out_order, 1);

    // table walk: R3 R4 R5 R6
    foreach (VEC[i]) begin
      for (int s = 1; s < 8; s++) wr(3'(s), 17'h01FFF);
      wr(3'd0, VEC[i].s0);
      if (VEC[i].sidx != 0) wr(VEC[i].sidx, VEC[i].sval);
      chk("R10 order follows", out_order == VEC[i].s0[14], out_order, VEC[i].s0[14]);
      clear_col(); exp_pid = VEC[i].pid;
      send(VEC[i].pid, PLEN, VEC[i].gap, 8'h47);
      drain();
      chk($sformatf("R6 vec%0d bytes", i), got_bytes == (VEC[i].exp ? PLEN : 0),
          got_bytes, VEC[i].exp ? PLEN : 0);
      chk($sformatf("R6 vec%0d starts", i), got_starts == int'(VEC[i].exp),
          got_starts, VEC[i].exp);
      chk($sformatf("R6 vec%0d data", i), mism == 0, mism, 0);
    end

    // R7 bad sync and stray bytes, under forward-all
    wr(3'd0, 17'h10000);
    clear_col(); exp_pid = 13'h0123;
    send(13'h0123, PLEN, 1'b0, 8'h46);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); in_valid = 1; in_start = 0; in_data = 8'h47;
    end
    @(negedge clk); in_valid = 0;
    drain();
    chk("R7 bad sync dropped", got_bytes == 0, got_bytes, 0);
    send(13'h0123, PLEN, 1'b0, 8'h47);
    drain();
    chk("R7 next good passes", got_bytes == PLEN && mism == 0, got_bytes, PLEN);

    // R9 first-byte latency
    clear_col(); exp_pid = 13'h0042;
    @(negedge clk); in_valid = 1; in_start = 1; in_data = 8'h47;
    @(negedge clk); in_start = 0; in_data = gen(13'h0042, 1);
    @(negedge clk); in_data = gen(13'h0042, 2);
    chk("R9 nothing before decision", out_valid == 0, out_valid, 0);
    @(negedge clk); in_valid = 0;
    chk("R9 first byte next cycle", out_valid && out_start && out_data == 8'h47,
        {out_valid, out_start, out_data}, 10'h347);
    @(negedge clk);
    chk("R9 second byte", out_valid && !out_start && out_data == gen(13'h0042, 1),
        out_data, gen(13'h0042, 1));

    // R8 restart mid-packet
    for (int k = 3; k < PLEN; k++) begin
      @(negedge clk); in_valid = 1; in_data = gen(13'h0042, k);
      if (k == 20) break;
    end
    send(13'h0042, PLEN, 1'b0, 8'h47);
    drain();
    chk("R8 restart starts", got_starts == 2, got_starts, 2);
    chk("R8 restart bytes", got_bytes == 21 + PLEN && mism == 0, got_bytes, 21 + PLEN);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule